// File: doc/BRIEF.md
# Alarm Wakeup and Kickstart Power Controller

This block lives in the always-on domain of a timekeeping subsystem and runs from the backup supply while the rest of the system is switched off. It requests main power in two cases. The first is a wakeup, when the calendar time equals a programmed alarm across day/date, hours, minutes and seconds. The second is a kickstart, when an external input is held low long enough to pass a minimum-width filter. The power request is an open-drain style line, modelled as an output-enable (`pwr_oe`) with a data value that is always 0.

After a request is raised, the block watches a main-supply-good indication. If that indication arrives within the power-on timeout, the request is held until main power goes away again. If it does not arrive, the request is released. Each cause leaves a sticky flag behind, which software clears through a dedicated clear input.

Calendar counting and supply comparison happen elsewhere. This block receives the current time as fields, together with a one-cycle strobe that marks each seconds update, and all of its timing is counted in cycles of the tick clock.

Top module: `wake_power_ctl`

## Requirements
- R1: After reset, `pwr_oe`, `wake_flag` and `ks_flag` are 0.
- R2: With `wake_en`=1 and `xfer_en`=1, a cycle with `sec_upd`=1 in which all four time fields equal their alarm fields sets `wake_flag` on the next edge. If the block is idle, the same edge also raises `pwr_oe`.
- R3: No wakeup occurs (no flag, and no request from idle) if `sec_upd`=0, if any one field differs from its alarm, or if `wake_en` or `xfer_en` is 0.
- R4: With `ks_en`=1 and `main_good`=0, the edge that samples `ks_n`=0 for the KS_MIN_LOW-th consecutive time sets `ks_flag`. If the block is idle, the same edge raises `pwr_oe`.
- R5: A low pulse on `ks_n` shorter than KS_MIN_LOW samples is ignored. A low pulse is also ignored while `ks_en`=0 or `main_good`=1.
- R6: If `main_good` stays 0 after a request, `pwr_oe` stays 1 for exactly PON_TIMEOUT edges and then returns to 0.
- R7: If `main_good` is 1 while the request is pending, `pwr_oe` stays 1 until the edge that samples `main_good`=0.
- R8: `wake_flag` and `ks_flag` remain set after a failed attempt. They are cleared only on an edge where `clr_wake_flag` or `clr_ks_flag` is 1 and no new event sets them in that same cycle.
- R9: `pwr_dat` is always 0.
- R10: A single low pulse on `ks_n`, however long, triggers at most one kickstart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_upd | input | 1 | One-cycle strobe on each seconds update |
| now_day | input | DW | Current day/date |
| now_hour | input | DW | Current hours |
| now_min | input | DW | Current minutes |
| now_sec | input | DW | Current seconds |
| alm_day | input | DW | Alarm day/date |
| alm_hour | input | DW | Alarm hours |
| alm_min | input | DW | Alarm minutes |
| alm_sec | input | DW | Alarm seconds |
| wake_en | input | 1 | Wakeup enable |
| xfer_en | input | 1 | Transfer enable, also required for wakeup |
| ks_en | input | 1 | Kickstart enable |
| ks_n | input | 1 | Active-low kickstart input |
| main_good | input | 1 | Main supply is good |
| clr_wake_flag | input | 1 | Software clear of the wakeup flag |
| clr_ks_flag | input | 1 | Software clear of the kickstart flag |
| pwr_oe | output | 1 | Power request driven (1) or released (0) |
| pwr_dat | output | 1 | Power request data value, constant 0 |
| wake_flag | output | 1 | Sticky wakeup flag |
| ks_flag | output | 1 | Sticky kickstart flag |

## Verification
The alarm match is tried four ways: with all fields equal, with exactly one field off for each field in turn, with each enable dropped, and with the strobe absent. These cases separate a correct four-way compare from one that ignores a field or a gate. Kickstart pulses of one sample below the minimum, exactly the minimum, and far beyond it show the filter threshold and the single-fire rule. Runs with `main_good` absent, arriving mid-wait and later dropping show the timeout path apart from the hold path. A seeded random phase then mixes all inputs and compares every cycle against a cycle model of the requirements.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
   typedef enum logic [1:0] {
      PS_IDLE = 2'd0,
      PS_WAIT = 2'd1,
      PS_ON   = 2'd2
   } pwr_state_e;

   localparam int NUM_FIELDS = 4;
endpackage

// File: rtl/wpc_alarm_match.sv
module wpc_alarm_match #(
   parameter int NF = 4,
   parameter int DW = 8
) (
   input  logic [NF-1:0][DW-1:0] now_v,
   input  logic [NF-1:0][DW-1:0] alm_v,
   input  logic                  strobe,
   input  logic                  enable,
   output logic                  hit
);
   logic [NF-1:0] eq;

   for (genvar f = 0; f < NF; f++) begin : g_field
      assign eq[f] = (now_v[f] == alm_v[f]);
   end

   assign hit = strobe & enable & (&eq);
endmodule

// File: rtl/wpc_ks_filter.sv
module wpc_ks_filter #(
   parameter int MIN_LOW = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ks_n,
   input  logic arm,
   output logic hit
);
   localparam int CW = $clog2(MIN_LOW + 1);
   localparam logic [CW-1:0] FIRE_AT = CW'(MIN_LOW - 1);
   localparam logic [CW-1:0] SAT_AT  = CW'(MIN_LOW);

   logic [CW-1:0] lo_cnt;

   // counts consecutive low samples, saturating one past the fire point
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_cnt <= '0;
      end else if (ks_n) begin
         lo_cnt <= '0;
      end else if (lo_cnt != SAT_AT) begin
         lo_cnt <= lo_cnt + 1'b1;
      end
   end

   assign hit = arm & ~ks_n & (lo_cnt == FIRE_AT);
endmodule

// File: rtl/wpc_pon_fsm.sv
module wpc_pon_fsm
   import wpc_pkg::*;
#(
   parameter int TIMEOUT = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic main_good,
   output logic pwr_oe
);
   localparam int TW = $clog2(TIMEOUT + 1);
   localparam logic [TW-1:0] LAST = TW'(TIMEOUT - 1);

   pwr_state_e     st;
   logic [TW-1:0]  tmr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= PS_IDLE;
         tmr <= '0;
      end else begin
         unique case (st)
            PS_IDLE: if (req) begin
               st  <= PS_WAIT;
               tmr <= '0;
            end
            PS_WAIT: if (main_good) begin
               st <= PS_ON;
            end else if (tmr == LAST) begin
               st <= PS_IDLE;
            end else begin
               tmr <= tmr + 1'b1;
            end
            PS_ON: if (!main_good) begin
               st <= PS_IDLE;
            end
            default: st <= PS_IDLE;
         endcase
      end
   end

   assign pwr_oe = (st != PS_IDLE);
endmodule

// File: rtl/wake_power_ctl.sv
module wake_power_ctl
   import wpc_pkg::*;
#(
   parameter int DW          = 8,
   parameter int KS_MIN_LOW  = 8,
   parameter int PON_TIMEOUT = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sec_upd,
   input  logic [DW-1:0] now_day,
   input  logic [DW-1:0] now_hour,
   input  logic [DW-1:0] now_min,
   input  logic [DW-1:0] now_sec,
   input  logic [DW-1:0] alm_day,
   input  logic [DW-1:0] alm_hour,
   input  logic [DW-1:0] alm_min,
   input  logic [DW-1:0] alm_sec,
   input  logic          wake_en,
   input  logic          xfer_en,
   input  logic          ks_en,
   input  logic          ks_n,
   input  logic          main_good,
   input  logic          clr_wake_flag,
   input  logic          clr_ks_flag,
   output logic          pwr_oe,
   output logic          pwr_dat,
   output logic          wake_flag,
   output logic          ks_flag
);
   if (DW < 1 || KS_MIN_LOW < 1 || PON_TIMEOUT < 1) begin : g_bad_param
      $error("wake_power_ctl: DW, KS_MIN_LOW and PON_TIMEOUT must be at least 1");
   end

   logic [NUM_FIELDS-1:0][DW-1:0] now_v, alm_v;
   logic wake_hit, ks_hit;

   assign now_v = {now_day, now_hour, now_min, now_sec};
   assign alm_v = {alm_day, alm_hour, alm_min, alm_sec};

   wpc_alarm_match #(.NF(NUM_FIELDS), .DW(DW)) u_match (
      .now_v  (now_v),
      .alm_v  (alm_v),
      .strobe (sec_upd),
      .enable (wake_en & xfer_en),
      .hit    (wake_hit)
   );

   wpc_ks_filter #(.MIN_LOW(KS_MIN_LOW)) u_ksf (
      .clk   (clk),
      .rst_n (rst_n),
      .ks_n  (ks_n),
      .arm   (ks_en & ~main_good),
      .hit   (ks_hit)
   );

   wpc_pon_fsm #(.TIMEOUT(PON_TIMEOUT)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (wake_hit | ks_hit),
      .main_good (main_good),
      .pwr_oe    (pwr_oe)
   );

   // sticky flags: a new event wins over a software clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wake_flag <= 1'b0;
         ks_flag   <= 1'b0;
      end else begin
         wake_flag <= wake_hit | (wake_flag & ~clr_wake_flag);
         ks_flag   <= ks_hit   | (ks_flag   & ~clr_ks_flag);
      end
   end

   assign pwr_dat = 1'b0;
endmodule

// File: rtl/wpc_checker.sv
module wpc_checker #(
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          sec_upd,
   input logic [DW-1:0] now_day,
   input logic [DW-1:0] now_hour,
   input logic [DW-1:0] now_min,
   input logic [DW-1:0] now_sec,
   input logic [DW-1:0] alm_day,
   input logic [DW-1:0] alm_hour,
   input logic [DW-1:0] alm_min,
   input logic [DW-1:0] alm_sec,
   input logic          wake_en,
   input logic          xfer_en,
   input logic          ks_en,
   input logic          ks_n,
   input logic          main_good,
   input logic          clr_wake_flag,
   input logic          clr_ks_flag,
   input logic          pwr_oe,
   input logic          pwr_dat,
   input logic          wake_flag,
   input logic          ks_flag
);
   logic full_match;
   assign full_match = sec_upd && wake_en && xfer_en &&
                       (now_day == alm_day) && (now_hour == alm_hour) &&
                       (now_min == alm_min) && (now_sec == alm_sec);

   assert_dat_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_dat == 1'b0);

   assert_wake_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
      full_match |=> wake_flag);

   assert_wake_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (full_match && !pwr_oe) |=> pwr_oe);

   assert_no_wake_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!wake_flag && !sec_upd) |=> !wake_flag);

   assert_idle_stays_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!pwr_oe && !sec_upd && (main_good || !ks_en)) |=> !pwr_oe);

   assert_ks_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ks_flag && (ks_n || !ks_en || main_good)) |=> !ks_flag);

   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_oe && main_good) |=> pwr_oe);

   assert_wflag_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_flag && !clr_wake_flag) |=> wake_flag);

   assert_kflag_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ks_flag && !clr_ks_flag) |=> ks_flag);
endmodule

bind wake_power_ctl wpc_checker #(.DW(DW)) u_chk (.*);

// File: tb/wake_power_ctl_tb.sv
module wake_power_ctl_tb;
   localparam int DW = 8;
   localparam int KS = 4;
   localparam int TO = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic sec_upd = 0, wake_en = 0, xfer_en = 0, ks_en = 0, ks_n = 1, main_good = 0;
   logic clr_wake_flag = 0, clr_ks_flag = 0;
   logic [DW-1:0] now_day = 0, now_hour = 0, now_min = 0, now_sec = 0;
   logic [DW-1:0] alm_day = 8'd3, alm_hour = 8'd7, alm_min = 8'd30, alm_sec = 8'd15;
   logic pwr_oe, pwr_dat, wake_flag, ks_flag;

   int checks = 0, errors = 0;
   bit done = 0;
   int m_lo = 0, m_st = 0, m_tmr = 0;
   bit m_wf = 0, m_kf = 0;

   wake_power_ctl #(.DW(DW), .KS_MIN_LOW(KS), .PON_TIMEOUT(TO)) u_dut (.*);

   always #2 clk = ~clk;

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   function automatic bit f_wake_hit();
      return sec_upd && wake_en && xfer_en && now_day == alm_day &&
             now_hour == alm_hour && now_min == alm_min && now_sec == alm_sec;
   endfunction

   function automatic bit f_ks_hit(input int lo);
      return !ks_n && lo == KS - 1 && ks_en && !main_good;
   endfunction

   // cycle model built from the requirements
   task automatic model_step();
      bit wh, kh;
      wh = f_wake_hit();
      kh = f_ks_hit(m_lo);
      m_lo = ks_n ? 0 : ((m_lo == KS) ? KS : m_lo + 1);
      case (m_st)
         0: if (wh || kh) begin m_st = 1; m_tmr = 0; end
         1: if (main_good) m_st = 2;
            else if (m_tmr == TO - 1) m_st = 0;
            else m_tmr++;
         default: if (!main_good) m_st = 0;
      endcase
      m_wf = wh | (m_wf & !clr_wake_flag);
      m_kf = kh | (m_kf & !clr_ks_flag);
   endtask

   task automatic tick(input string tag);
      model_step();
      @(posedge clk);
      #1;
      chk(tag, "pwr_oe", pwr_oe, int'(m_st != 0));
      chk(tag, "wake_flag", wake_flag, m_wf);
      chk(tag, "ks_flag", ks_flag, m_kf);
      chk("R9", "pwr_dat", pwr_dat, 0);
   endtask

   task automatic set_now_to_alarm();
      now_day = alm_day; now_hour = alm_hour; now_min = alm_min; now_sec = alm_sec;
   endtask

   task automatic clear_flags();
      clr_wake_flag = 1; clr_ks_flag = 1;
      tick("R8");
      clr_wake_flag = 0; clr_ks_flag = 0;
   endtask

   task automatic idle_out(input string tag);
      sec_upd = 0; main_good = 0; ks_n = 1;
      for (int i = 0; i < TO + 2; i++) tick(tag);
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int on_cnt;
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1;
      #0;
      chk("R1", "pwr_oe", pwr_oe, 0);
      chk("R1", "wake_flag", wake_flag, 0);
      chk("R1", "ks_flag", ks_flag, 0);

      // R2 + R6: wakeup, then timeout with no main supply
      wake_en = 1; xfer_en = 1; ks_en = 1;
      set_now_to_alarm();
      sec_upd = 1;
      tick("R2");
      chk("R2", "pwr_oe after match", pwr_oe, 1);
      chk("R2", "wake_flag after match", wake_flag, 1);
      sec_upd = 0;
      on_cnt = 1;
      for (int i = 0; i < TO + 3; i++) begin
         tick("R6");
         if (pwr_oe) on_cnt++;
      end
      chk("R6", "request edges", on_cnt, TO);
      chk("R8", "wake_flag after failed attempt", wake_flag, 1);
      clear_flags();
      chk("R8", "wake_flag after clear", wake_flag, 0);

      // R3: each field off by one, each enable off, no strobe
      for (int f = 0; f < 4; f++) begin
         set_now_to_alarm();
         case (f)
            0: now_day  = alm_day + 1;
            1: now_hour = alm_hour + 1;
            2: now_min  = alm_min + 1;
            default: now_sec = alm_sec + 1;
         endcase
         sec_upd = 1;
         tick("R3");
         chk("R3", "pwr_oe field mismatch", pwr_oe, 0);
         sec_upd = 0;
         tick("R3");
      end
      set_now_to_alarm();
      wake_en = 0; sec_upd = 1; tick("R3");
      chk("R3", "wake_flag wake_en off", wake_flag, 0);
      wake_en = 1; xfer_en = 0; tick("R3");
      chk("R3", "wake_flag xfer_en off", wake_flag, 0);
      xfer_en = 1; sec_upd = 0; tick("R3");
      chk("R3", "pwr_oe no strobe", pwr_oe, 0);
      now_sec = alm_sec + 2;

      // R5: short kickstart pulse
      ks_n = 0;
      for (int i = 0; i < KS - 1; i++) tick("R5");
      ks_n = 1; tick("R5");
      chk("R5", "ks_flag short pulse", ks_flag, 0);
      chk("R5", "pwr_oe short pulse", pwr_oe, 0);

      // R5: kickstart disabled, and main supply present
      ks_en = 0; ks_n = 0;
      for (int i = 0; i < KS + 2; i++) tick("R5");
      chk("R5", "ks_flag ks_en off", ks_flag, 0);
      ks_n = 1; tick("R5");
      ks_en = 1; main_good = 1; ks_n = 0;
      for (int i = 0; i < KS + 2; i++) tick("R5");
      chk("R5", "ks_flag main_good on", ks_flag, 0);
      ks_n = 1; main_good = 0; tick("R5");

      // R4 + R10: exact-width pulse held long
      ks_n = 0;
      for (int i = 0; i < KS - 1; i++) tick("R4");
      chk("R4", "pwr_oe before width met", pwr_oe, 0);
      tick("R4");
      chk("R4", "pwr_oe at width", pwr_oe, 1);
      chk("R4", "ks_flag at width", ks_flag, 1);
      for (int i = 0; i < 3 * TO; i++) tick("R10");
      chk("R10", "pwr_oe long pulse no refire", pwr_oe, 0);
      ks_n = 1; tick("R10");
      clear_flags();

      // R7: main supply arrives while waiting
      ks_n = 0;
      for (int i = 0; i < KS; i++) tick("R7");
      ks_n = 1; tick("R7");
      main_good = 1;
      for (int i = 0; i < 3 * TO; i++) tick("R7");
      chk("R7", "pwr_oe held", pwr_oe, 1);
      main_good = 0; tick("R7");
      chk("R7", "pwr_oe after supply loss", pwr_oe, 0);
      clear_flags();

      // seeded random mix, every cycle against the model
      for (int c = 0; c < 6000; c++) begin
         sec_upd = ($urandom % 4) == 0;
         now_day  = alm_day  + DW'($urandom % 2 & ($urandom % 3 == 0));
         now_hour = alm_hour + DW'($urandom % 5 == 0);
         now_min  = alm_min  + DW'($urandom % 5 == 0);
         now_sec  = alm_sec  + DW'($urandom % 5 == 0);
         wake_en = ($urandom % 8) != 0;
         xfer_en = ($urandom % 8) != 0;
         ks_en   = ($urandom % 6) != 0;
         if ($urandom % 6 == 0) ks_n = ~ks_n;
         if ($urandom % 25 == 0) main_good = ~main_good;
         clr_wake_flag = ($urandom % 16) == 0;
         clr_ks_flag   = ($urandom % 16) == 0;
         tick("R2,R4,R6,R7,R8");
      end
      idle_out("R6");

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule